// File: doc/BRIEF.md
# Nonvolatile Write Sequencer

This block sequences writes into a 128-word by 16-bit nonvolatile store, modelled here as a register array. It receives command frames serially: the chip select `cs_n` is active low, each pulse on `bit_stb` marks one serial clock rise and carries one bit on `bit_in`, most significant bit first. A frame opens with an 8-bit command code, then an address byte of which only the low seven bits are used. A word write adds 16 data bits after that. A separate write-enable latch is set and cleared by its own commands and comes up cleared. A write is refused while the latch is clear.

An accepted write starts a programming period of `PROG_CYCLES` system clocks. A word write starts it after its 32nd bit. A wiper store starts it after its 16th bit and copies the 7-bit `wiper_pos` input into bits 14..8 of the addressed word, leaving the other bits unchanged. While `busy` is high every input bit is ignored. Once the period ends, chip select must go high and then low again before the next frame is accepted. Programming only commits its word if chip select was seen high at some point after the final bit. A write left with chip select held low is therefore cancelled. The store can be read at any time through `rd_addr`/`rd_data`.

The controller is one state machine with five states. IDLE waits for selection and goes to SHIFT when `cs_n` falls. SHIFT gathers bits. It returns to IDLE if `cs_n` rises. After the 16th bit it goes to HOLD (latch commands, unknown codes, or a refused wiper store), to BUSY (an accepted wiper store), or stays in SHIFT (word write). After the 32nd bit it goes to BUSY or HOLD. HOLD ignores bits until `cs_n` rises, then goes to IDLE. BUSY counts the programming period and leaves for REARM on its last cycle. REARM ignores bits until `cs_n` is high, then goes to IDLE.

Top module: `nvws_top`

## Requirements
- R1: After reset the write-enable latch is clear, `busy` is low and every word of the store reads zero.
- R2: Command code 0xC3 sets the latch and 0xC0 clears it, each taking effect on the 16th bit of its frame. The latch keeps its value across all other traffic.
- R3: Command code 0xC9 is a word write. Its frame is the code, then an address byte whose bit 7 is ignored, then 16 data bits, all most significant bit first. When the latch is set, the word is stored at the address at the end of programming.
- R4: Command code 0xC6 is a wiper store. When the latch is set, `wiper_pos` sampled with the 16th bit replaces bits 14..8 of the addressed word at the end of programming, and bits 15 and 7..0 keep their old value.
- R5: `busy` rises in the cycle after the bit that completes an accepted write and stays high for exactly `PROG_CYCLES` clocks.
- R6: While `busy` is high, chip select and input bits have no effect: no latch change and no new write.
- R7: After programming ends, a frame sent without `cs_n` first going high and then low again is ignored.
- R8: A write commits only if `cs_n` is sampled high in at least one cycle from the cycle after its final bit through the last `busy` cycle. Otherwise the store is left unchanged.
- R9: A word write or wiper store received while the latch is clear changes nothing and does not raise `busy`.
- R10: A frame ended by `cs_n` rising before its required bits have arrived changes no word and does not raise `busy`.
- R11: Bits after a finished latch command, and whole frames with an unknown command code, are ignored until `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cs_n | input | 1 | Chip select, active low |
| bit_stb | input | 1 | One-cycle pulse per serial clock rise |
| bit_in | input | 1 | Serial data bit, valid with `bit_stb` |
| wiper_pos | input | 7 | Current wiper position to be stored |
| rd_addr | input | 7 | Store read address |
| rd_data | output | 16 | Store word at `rd_addr` |
| busy | output | 1 | Programming period in progress |
| wr_enabled | output | 1 | Write-enable latch state |

## Verification
The bench builds the block with a programming period of 40 clocks instead of the real-time default. A whole busy window then fits inside a short run, and so does a complete frame sent during it. Both sides of every window edge can be observed: the first and last busy cycle, the deselect seen or missed inside the window, and the selection toggle needed after it. The seven-bit address and 16-bit word keep their default widths, so the extreme address and the bits on either side of the wiper field are exercised.

// File: rtl/nvws_pkg.sv
package nvws_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_HOLD,
        ST_BUSY,
        ST_REARM
    } seq_state_t;

    localparam int          OP_W     = 8;
    localparam int          HDR_BITS = 2 * OP_W;

    localparam logic [OP_W-1:0] OP_WREN  = 8'hC3;
    localparam logic [OP_W-1:0] OP_WRDIS = 8'hC0;
    localparam logic [OP_W-1:0] OP_MEMWR = 8'hC9;
    localparam logic [OP_W-1:0] OP_WIPST = 8'hC6;

endpackage

// File: rtl/nvws_shifter.sv
module nvws_shifter #(
    parameter int SH_W  = 16,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift,
    input  logic             bit_in,
    output logic [SH_W-1:0]  frame_next,
    output logic [CNT_W-1:0] count
);

    logic [SH_W-1:0] shreg;

    // Value the register takes if this cycle's bit is accepted
    assign frame_next = {shreg[SH_W-2:0], bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            count <= '0;
        end else if (clear) begin
            shreg <= '0;
            count <= '0;
        end else if (shift) begin
            shreg <= frame_next;
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/nvws_prog_timer.sv
module nvws_prog_timer #(
    parameter int PROG_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= CW'(PROG_CYCLES);
        end else if (run && remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    // High in the final cycle of the programming window
    assign done = run && (remain == CW'(1));

endmodule

// File: rtl/nvws_store.sv
module nvws_store #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] wmask,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[waddr] <= (cells[waddr] & ~wmask) | (wdata & wmask);
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/nvws_top.sv
module nvws_top
    import nvws_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int WIPER_W     = 7,
    parameter int WIPER_LSB   = 8,
    parameter int PROG_CYCLES = 500000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               bit_stb,
    input  logic               bit_in,
    input  logic [WIPER_W-1:0] wiper_pos,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               busy,
    output logic               wr_enabled
);

    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [DATA_W-1:0] WIP_MASK =
        DATA_W'((1 << WIPER_W) - 1) << WIPER_LSB;

    seq_state_t state, state_nxt;

    logic [DATA_W-1:0] frame_next;
    logic [CNT_W-1:0]  count;
    logic              shift_en;
    logic              hdr_done;
    logic              full_done;
    logic [OP_W-1:0]   hdr_op;

    logic              set_we;
    logic              clr_we;
    logic              start_word;
    logic              start_wip;
    logic              start_prog;
    logic              tmr_done;
    logic              mem_we;
    logic              we_q;
    logic              desel_q;

    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;
    logic [DATA_W-1:0] pend_mask;

    // ---------------------------------------------------------------
    // Frame assembly
    // ---------------------------------------------------------------
    assign shift_en  = (state == ST_SHIFT) && !cs_n && bit_stb;
    assign hdr_done  = shift_en && (count == CNT_W'(HDR_BITS - 1));
    assign full_done = shift_en && (count == CNT_W'(FRAME_BITS - 1));
    assign hdr_op    = frame_next[HDR_BITS-1 -: OP_W];

    nvws_shifter #(
        .SH_W  (DATA_W),
        .CNT_W (CNT_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (state != ST_SHIFT),
        .shift      (shift_en),
        .bit_in     (bit_in),
        .frame_next (frame_next),
        .count      (count)
    );

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!cs_n) state_nxt = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_n) begin
                    state_nxt = ST_IDLE;
                end else if (hdr_done) begin
                    unique case (hdr_op)
                        OP_MEMWR: state_nxt = ST_SHIFT;
                        OP_WIPST: state_nxt = we_q ? ST_BUSY : ST_HOLD;
                        default:  state_nxt = ST_HOLD;
                    endcase
                end else if (full_done) begin
                    state_nxt = we_q ? ST_BUSY : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (cs_n) state_nxt = ST_IDLE;
            end
            ST_BUSY: begin
                if (tmr_done) state_nxt = ST_REARM;
            end
            ST_REARM: begin
                if (cs_n) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // Output / action decode
    // ---------------------------------------------------------------
    always_comb begin
        set_we     = 1'b0;
        clr_we     = 1'b0;
        start_word = 1'b0;
        start_wip  = 1'b0;
        mem_we     = 1'b0;
        busy       = 1'b0;
        unique case (state)
            ST_SHIFT: begin
                if (hdr_done) begin
                    set_we    = (hdr_op == OP_WREN);
                    clr_we    = (hdr_op == OP_WRDIS);
                    start_wip = (hdr_op == OP_WIPST) && we_q;
                end
                start_word = full_done && we_q;
            end
            ST_BUSY: begin
                busy   = 1'b1;
                mem_we = tmr_done && (desel_q || cs_n);
            end
            default: ;
        endcase
    end

    assign start_prog = start_word || start_wip;
    assign wr_enabled = we_q;

    // ---------------------------------------------------------------
    // Write-enable latch
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q <= 1'b0;
        end else if (set_we) begin
            we_q <= 1'b1;
        end else if (clr_we) begin
            we_q <= 1'b0;
        end
    end

    // ---------------------------------------------------------------
    // Pending write and deselect tracking
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_data <= '0;
            pend_mask <= '0;
            desel_q   <= 1'b0;
        end else begin
            if (hdr_done) begin
                pend_addr <= frame_next[ADDR_W-1:0];
            end
            if (start_word) begin
                pend_data <= frame_next;
                pend_mask <= '1;
            end else if (start_wip) begin
                pend_data <= DATA_W'(wiper_pos) << WIPER_LSB;
                pend_mask <= WIP_MASK;
            end
            if (start_prog) begin
                desel_q <= 1'b0;
            end else if (state == ST_BUSY && cs_n) begin
                desel_q <= 1'b1;
            end
        end
    end

    nvws_prog_timer #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_prog),
        .run   (state == ST_BUSY),
        .done  (tmr_done)
    );

    nvws_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (pend_addr),
        .wdata (pend_data),
        .wmask (pend_mask),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/nvws_checker.sv
module nvws_checker #(
    parameter int PROG_CYCLES = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic wr_enabled,
    input logic mem_we
);

    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= 0;
        end else begin
            run_len <= busy ? run_len + 1 : 0;
        end
    end

    AST_BUSY_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wr_enabled));  // R6

    AST_PROG_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wr_enabled);  // R9

    AST_COMMIT_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);  // R8

    AST_BUSY_NOT_OVERLONG: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < PROG_CYCLES));  // R5

    AST_BUSY_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == PROG_CYCLES));  // R5

endmodule

bind nvws_top nvws_checker #(
    .PROG_CYCLES (PROG_CYCLES)
) u_nvws_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .wr_enabled (wr_enabled),
    .mem_we     (mem_we)
);

// File: tb/nvws_top_test.sv
module nvws_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int P          = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        bit_stb = 1'b0;
    logic        bit_in = 1'b0;
    logic [6:0]  wiper_pos = '0;
    logic [6:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        busy;
    logic        wr_enabled;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;
    int run_cnt  = 0;
    int last_run = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nvws_top #(
        .ADDR_W      (7),
        .DATA_W      (16),
        .WIPER_W     (7),
        .WIPER_LSB   (8),
        .PROG_CYCLES (P)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .bit_stb    (bit_stb),
        .bit_in     (bit_in),
        .wiper_pos  (wiper_pos),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .busy       (busy),
        .wr_enabled (wr_enabled)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_cnt, m_left, m_paddr;
    bit          m_active, m_lock, m_rearm, m_desel, m_we;
    logic [15:0] m_sh, m_pdata, m_pmask;
    logic [15:0] m_mem [128];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_left = 0; m_paddr = 0;
            m_active = 0; m_lock = 0; m_rearm = 0; m_desel = 0; m_we = 0;
            m_sh = 0; m_pdata = 0; m_pmask = 0;
            for (int i = 0; i < 128; i++) m_mem[i] = 16'h0000;
        end else if (m_left > 0) begin
            if (cs_n) m_desel = 1;
            m_left--;
            if (m_left == 0) begin
                if (m_desel)
                    m_mem[m_paddr] = (m_mem[m_paddr] & ~m_pmask) | (m_pdata & m_pmask);
                m_rearm = 1;
            end
        end else if (m_rearm) begin
            if (cs_n) begin m_rearm = 0; m_active = 0; m_lock = 0; m_cnt = 0; end
        end else if (cs_n) begin
            m_active = 0; m_lock = 0; m_cnt = 0;
        end else if (!m_active) begin
            m_active = 1; m_cnt = 0;
        end else if (bit_stb && !m_lock) begin
            m_sh = {m_sh[14:0], bit_in};
            m_cnt++;
            if (m_cnt == 16) begin
                m_paddr = int'(m_sh[6:0]);
                case (m_sh[15:8])
                    8'hC3: begin m_we = 1; m_lock = 1; end
                    8'hC0: begin m_we = 0; m_lock = 1; end
                    8'hC9: ;
                    8'hC6: begin
                        m_lock = 1;
                        if (m_we) begin
                            m_left = P; m_desel = 0;
                            m_pdata = {1'b0, wiper_pos, 8'h00};
                            m_pmask = 16'h7F00;
                        end
                    end
                    default: m_lock = 1;
                endcase
            end else if (m_cnt == 32) begin
                m_lock = 1;
                if (m_we) begin
                    m_left = P; m_desel = 0;
                    m_pdata = m_sh; m_pmask = 16'hFFFF;
                end
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 per-cycle busy", {31'd0, busy}, {31'd0, (m_left > 0)});
            chk("R2 per-cycle latch", {31'd0, wr_enabled}, {31'd0, m_we});
            chk("R3 per-cycle store word", {16'd0, rd_data}, {16'd0, m_mem[rd_addr]});
            if (busy) run_cnt++;
            else begin
                if (run_cnt != 0) last_run = run_cnt;
                run_cnt = 0;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected below 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] frm(input logic [7:0] op, input logic [7:0] ab,
                                        input logic [15:0] d);
        return {op, ab, d};
    endfunction

    task automatic send_frame(input logic [31:0] bits, input int n, input bit raise);
        cs_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            bit_in  = bits[31-i];
            bit_stb = 1'b1;
            @(negedge clk);
            bit_stb = 1'b0;
            @(negedge clk);
        end
        if (raise) begin
            cs_n = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < P + 10; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic peek(input logic [6:0] a, input string req, input logic [15:0] exp);
        rd_addr = a;
        #1;
        chk(req, {16'd0, rd_data}, {16'd0, exp});
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: power-up state
        chk("R1 latch after reset", {31'd0, wr_enabled}, 32'd0);
        chk("R1 busy after reset", {31'd0, busy}, 32'd0);
        peek(7'd0, "R1 word 0 after reset", 16'h0000);
        peek(7'd127, "R1 word 127 after reset", 16'h0000);

        // R9: word write with latch clear
        send_frame(frm(8'hC9, 8'h05, 16'h1111), 32, 1);
        chk("R9 no busy with latch clear", {31'd0, busy}, 32'd0);
        peek(7'd5, "R9 word unchanged", 16'h0000);

        // R2: enable
        send_frame(frm(8'hC3, 8'h00, 16'h0), 16, 1);
        chk("R2 latch set", {31'd0, wr_enabled}, 32'd1);

        // R3/R5/R8: word write, address byte bit 7 ignored, deselect seen
        send_frame(frm(8'hC9, 8'h85, 16'hA5C3), 32, 1);
        chk("R5 busy after final bit", {31'd0, busy}, 32'd1);
        // R6: a disable frame during programming is ignored
        send_frame(frm(8'hC0, 8'h00, 16'h0), 16, 1);
        wait_idle();
        chk("R6 latch kept through busy", {31'd0, wr_enabled}, 32'd1);
        chk("R5 busy window length", last_run, P);
        peek(7'd5, "R3 word stored", 16'hA5C3);

        // R8/R7: write with chip select held low -> cancelled
        send_frame(frm(8'hC9, 8'h09, 16'hBEEF), 32, 0);
        repeat (P + 5) @(negedge clk);
        chk("R8 busy ended", {31'd0, busy}, 32'd0);
        peek(7'd9, "R8 cancelled write leaves word", 16'h0000);
        send_frame(frm(8'hC0, 8'h00, 16'h0), 16, 1);
        chk("R7 frame without reselect ignored", {31'd0, wr_enabled}, 32'd1);
        send_frame(frm(8'hC0, 8'h00, 16'h0), 16, 1);
        chk("R7 frame after reselect taken", {31'd0, wr_enabled}, 32'd0);
        send_frame(frm(8'hC3, 8'h00, 16'h0), 16, 1);

        // R4: wiper store merges into bits 14..8
        send_frame(frm(8'hC9, 8'h14, 16'h1234), 32, 1);
        wait_idle();
        wiper_pos = 7'h55;
        send_frame(frm(8'hC6, 8'h14, 16'h0), 16, 1);
        wiper_pos = 7'h00;
        chk("R5 busy after wiper store", {31'd0, busy}, 32'd1);
        wait_idle();
        peek(7'd20, "R4 wiper field merged", 16'h5534);
        send_frame(frm(8'hC9, 8'h7F, 16'hFFFF), 32, 1);
        wait_idle();
        send_frame(frm(8'hC6, 8'h7F, 16'h0), 16, 1);
        wait_idle();
        peek(7'd127, "R4 outer bits kept", 16'h80FF);

        // R10: early deselect
        send_frame(frm(8'hC9, 8'h03, 16'h7777), 20, 1);
        chk("R10 no busy after short frame", {31'd0, busy}, 32'd0);
        peek(7'd3, "R10 word unchanged", 16'h0000);

        // R11: trailing bits and unknown codes
        send_frame(frm(8'hC0, 8'h00, 16'hC300), 32, 1);
        chk("R11 trailing enable ignored", {31'd0, wr_enabled}, 32'd0);
        send_frame(frm(8'h5A, 8'h00, 16'hC300), 32, 1);
        chk("R11 unknown code ignored", {31'd0, wr_enabled}, 32'd0);
        wiper_pos = 7'h2A;
        send_frame(frm(8'hC6, 8'h14, 16'h0), 16, 1);
        chk("R9 wiper store refused", {31'd0, busy}, 32'd0);
        repeat (3) @(negedge clk);
        peek(7'd20, "R9 word unchanged by refused store", 16'h5534);
        send_frame(frm(8'hC3, 8'h00, 16'hC000), 32, 1);
        chk("R2 latch set, trailing disable ignored", {31'd0, wr_enabled}, 32'd1);

        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule